// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides which low-power state a small processor system is in and drives the clock enables for that state. Software picks the state by writing a byte to the mode register. The state machine then moves between run, CPU sleep and standby. CPU sleep is the light state. Only the CPU clock stops, and the memory, cache, memory controller and external bus keep running.

Standby is the deep state. To enter it, the block works through a fixed sequence of handshakes: bus drain, then cache purge, then memory self-refresh. After that it gates the system clocks and turns off the PLL, and it pulls an active-low standby flag low. The bus, cache, memory and PLL are outside this block. They are seen only through request/acknowledge pins.

Each state has its own wake sources. CPU sleep is left on the interrupt input or the bus-interface wake input. Standby is left on the standby wake input. All three wake inputs are active low and pass through a synchronizer of `SYNC_STAGES` flops. The asynchronous reset leaves either state. On any wake, the PLL is enabled first. The clocks come back only after the PLL reports lock, and the mode field then clears.

Top module: `lpm_ctrl`

## Requirements
- R1: While and after reset, `reg_rdata_o` is 0x00, `cpu_clk_en_o`, `clk_en_o`, `pll_en_o` and `stby_no` are 1, and the three request outputs are 0.
- R2: The mode field is bits [1:0] of the register. Bits [7:2] always read as 0, whatever value was written.
- R3: In run, writing code 2'b10 to bits [1:0] enters CPU sleep one cycle later. The readback becomes 0x02 and `cpu_clk_en_o` drops. `clk_en_o`, `pll_en_o` and `stby_no` stay 1, and `sref_req_o` stays 0.
- R4: CPU sleep is left when the synchronized `irq_ni` or `bus_wake_ni` is low. The return to run clears the mode field to 2'b00 and raises `cpu_clk_en_o`. `wake_ni` has no effect in CPU sleep.
- R5: A write of the reserved code 2'b01, or of 2'b00, changes neither the readback nor any output.
- R6: Writing code 2'b11 in run raises `drain_req_o` one cycle later. Each acknowledge then advances the sequence by one step:
  - `drain_ack_i` swaps the request to `purge_req_o`.
  - `purge_ack_i` swaps it to `sref_req_o`.
  - `sref_ack_i` drops `cpu_clk_en_o` and `clk_en_o`.
  - One cycle later, `pll_en_o` and `stby_no` go low.
- R7: Each entry request stays high, and the sequence does not advance, for as long as its acknowledge stays low.
- R8: In standby, a synchronized low on `wake_ni` raises `pll_en_o` and `stby_no`. The clocks stay gated and `sref_req_o` stays high until `pll_lock_i` is seen. One cycle after lock, all enables are 1, `sref_req_o` is 0 and the readback is 0x00. `irq_ni` and `bus_wake_ni` have no effect in standby.
- R9: A low on `wake_ni` that is seen during the entry sequence is remembered. Standby then lasts one cycle, and the PLL is re-enabled at once.
- R10: Asserting `rst_ni` in any state immediately restores the R1 values.
- R11: Register writes are ignored in every state other than run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; also leaves any low-power state |
| reg_we_i | input | 1 | Mode register write strobe |
| reg_wdata_i | input | DATA_W | Mode register write data |
| reg_rdata_o | output | DATA_W | Mode register readback |
| wake_ni | input | 1 | Standby wake, active low, asynchronous |
| irq_ni | input | 1 | Interrupt wake for CPU sleep, active low, asynchronous |
| bus_wake_ni | input | 1 | Bus-interface wake for CPU sleep, active low, asynchronous |
| drain_req_o | output | 1 | Request to finish the bus transfer in flight |
| drain_ack_i | input | 1 | Bus idle acknowledge |
| purge_req_o | output | 1 | Cache purge request |
| purge_ack_i | input | 1 | Cache purge done |
| sref_req_o | output | 1 | Memory self-refresh request, held through standby |
| sref_ack_i | input | 1 | Memory is in self-refresh |
| pll_en_o | output | 1 | PLL enable |
| pll_lock_i | input | 1 | PLL lock indication |
| clk_en_o | output | 1 | System clock enable for memory, cache and bus |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| stby_no | output | 1 | Standby reached, active low |

## Verification
Register readback and the entry-sequence outputs change one rising edge after the write or acknowledge that causes them. A wake input needs `SYNC_STAGES` edges to cross the synchronizer and one more edge to move the state. A PLL lock takes effect on the next edge, and reset takes effect with no clock at all. The bench drives every input on the falling edge and counts out exactly those rising edges before it samples on the next falling edge. It also samples one edge early, to confirm that nothing has changed yet. After each exit it idles for the synchronizer depth, so that an old wake level cannot leak into the next sequence.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_DRAIN, ST_PURGE, ST_SREF, ST_GATE, ST_STBY, ST_RELOCK
  } lpm_state_e;

  localparam int unsigned MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_RUN   = 2'b00;
  localparam logic [MODE_W-1:0] MODE_RSVD  = 2'b01;
  localparam logic [MODE_W-1:0] MODE_SLEEP = 2'b10;
  localparam logic [MODE_W-1:0] MODE_STBY  = 2'b11;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= RST_VAL;
      else         stg_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              accept_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              go_sleep_o,
  output logic              go_stby_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PAD_W = DATA_W - MODE_W;

  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] code;
  logic              wr_ok;

  assign code       = wdata_i[MODE_W-1:0];
  assign wr_ok      = we_i && accept_i;
  assign go_sleep_o = wr_ok && (code == MODE_SLEEP);
  assign go_stby_o  = wr_ok && (code == MODE_STBY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= MODE_RUN;
    else if (clr_i)                   mode_q <= MODE_RUN;
    else if (go_sleep_o || go_stby_o) mode_q <= code;
  end

  assign rdata_o = {{PAD_W{1'b0}}, mode_q};

  // R5: reserved code leaves the field alone
  p_rsvd_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && code == MODE_RSVD && !clr_i) |=> $stable(mode_q));

  // R11: writes outside run are dropped
  p_busy_wr_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !accept_i && !clr_i) |=> $stable(mode_q));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_sleep_i,
  input  logic       go_stby_i,
  input  logic       wake_n_i,
  input  logic       irq_n_i,
  input  logic       bus_wake_n_i,
  input  logic       drain_ack_i,
  input  logic       purge_ack_i,
  input  logic       sref_ack_i,
  input  logic       pll_lock_i,
  output lpm_state_e state_o,
  output logic       run_o,
  output logic       clr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  lpm_state_e state_q, state_d;
  logic       wake_pend_q;
  logic       in_entry;

  assign in_entry = (state_q == ST_DRAIN) || (state_q == ST_PURGE) ||
                    (state_q == ST_SREF)  || (state_q == ST_GATE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (go_stby_i) state_d = ST_DRAIN;
                 else if (go_sleep_i) state_d = ST_SLEEP;
      ST_SLEEP:  if (!irq_n_i || !bus_wake_n_i) state_d = ST_RUN;
      ST_DRAIN:  if (drain_ack_i) state_d = ST_PURGE;
      ST_PURGE:  if (purge_ack_i) state_d = ST_SREF;
      ST_SREF:   if (sref_ack_i) state_d = ST_GATE;
      ST_GATE:   state_d = ST_STBY;
      ST_STBY:   if (wake_pend_q || !wake_n_i) state_d = ST_RELOCK;
      ST_RELOCK: if (pll_lock_i) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  // wake seen mid-entry is held until clocks are down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    wake_pend_q <= 1'b0;
    else if (state_q == ST_STBY)    wake_pend_q <= 1'b0;
    else if (in_entry && !wake_n_i) wake_pend_q <= 1'b1;
  end

  assign state_o = state_q;
  assign run_o   = (state_q == ST_RUN);
  assign clr_o   = (state_q != ST_RUN) && (state_d == ST_RUN);

  p_drain_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && !drain_ack_i) |=> state_q == ST_DRAIN);
  p_purge_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PURGE && !purge_ack_i) |=> state_q == ST_PURGE);
  p_purge_after_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PURGE && $past(state_q) != ST_PURGE) |-> $past(drain_ack_i));
  p_sref_after_purge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SREF && $past(state_q) != ST_SREF) |-> $past(purge_ack_i));
  p_pend_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && wake_pend_q) |=> state_q == ST_RELOCK);
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  output logic       cpu_clk_en_o,
  output logic       clk_en_o,
  output logic       pll_en_o,
  output logic       stby_no,
  output logic       drain_req_o,
  output logic       purge_req_o,
  output logic       sref_req_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [6:0] v;

  // {cpu, clk, pll, stby_n, drain, purge, sref}
  always_comb begin
    unique case (state_i)
      ST_RUN:    v = 7'b1111_000;
      ST_SLEEP:  v = 7'b0111_000;
      ST_DRAIN:  v = 7'b1111_100;
      ST_PURGE:  v = 7'b1111_010;
      ST_SREF:   v = 7'b1111_001;
      ST_GATE:   v = 7'b0011_001;
      ST_STBY:   v = 7'b0000_001;
      ST_RELOCK: v = 7'b0011_001;
      default:   v = 7'b1111_000;
    endcase
  end

  assign {cpu_clk_en_o, clk_en_o, pll_en_o, stby_no,
          drain_req_o, purge_req_o, sref_req_o} = v;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              wake_ni,
  input  logic              irq_ni,
  input  logic              bus_wake_ni,
  output logic              drain_req_o,
  input  logic              drain_ack_i,
  output logic              purge_req_o,
  input  logic              purge_ack_i,
  output logic              sref_req_o,
  input  logic              sref_ack_i,
  output logic              pll_en_o,
  input  logic              pll_lock_i,
  output logic              clk_en_o,
  output logic              cpu_clk_en_o,
  output logic              stby_no
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned N_WAKE = 3;

  logic [N_WAKE-1:0] wake_raw, wake_s;
  logic              go_sleep, go_stby, run, clr;
  lpm_state_e        state;

  assign wake_raw = {wake_ni, irq_ni, bus_wake_ni};

  lpm_sync #(.WIDTH(N_WAKE), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wake_raw),
    .q_o   (wake_s)
  );

  lpm_mode_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .accept_i  (run),
    .clr_i     (clr),
    .rdata_o   (reg_rdata_o),
    .go_sleep_o(go_sleep),
    .go_stby_o (go_stby)
  );

  lpm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_sleep_i  (go_sleep),
    .go_stby_i   (go_stby),
    .wake_n_i    (wake_s[2]),
    .irq_n_i     (wake_s[1]),
    .bus_wake_n_i(wake_s[0]),
    .drain_ack_i (drain_ack_i),
    .purge_ack_i (purge_ack_i),
    .sref_ack_i  (sref_ack_i),
    .pll_lock_i  (pll_lock_i),
    .state_o     (state),
    .run_o       (run),
    .clr_o       (clr)
  );

  lpm_clk_ctrl u_clk (
    .state_i     (state),
    .cpu_clk_en_o(cpu_clk_en_o),
    .clk_en_o    (clk_en_o),
    .pll_en_o    (pll_en_o),
    .stby_no     (stby_no),
    .drain_req_o (drain_req_o),
    .purge_req_o (purge_req_o),
    .sref_req_o  (sref_req_o)
  );

  // R6: PLL drops only after clocks are gated and memory is in self-refresh
  p_pll_after_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_en_o) |-> $past(!clk_en_o && !cpu_clk_en_o && sref_req_o));
  // R8: clocks return only after PLL lock
  p_clk_after_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_en_o) && $past(pll_en_o)) |-> $past(pll_lock_i));
  // R3: memory side keeps running while only the CPU is stopped
  p_sleep_mem_alive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && !sref_req_o) |-> (clk_en_o && pll_en_o && stby_no));
  // R4: sleep exit clears the mode field
  p_exit_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_clk_en_o) && $past(!sref_req_o)) |-> reg_rdata_o == '0);
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W = 8;
  localparam int SYNC   = 2;

  typedef enum int {P_RUN, P_SLEEP, P_DRAIN, P_PURGE, P_SREF, P_GATE, P_STBY, P_RELOCK} phase_e;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o;
  logic wake_ni = 1'b1, irq_ni = 1'b1, bus_wake_ni = 1'b1;
  logic drain_req_o, purge_req_o, sref_req_o;
  logic drain_ack_i = 1'b0, purge_ack_i = 1'b0, sref_ack_i = 1'b0;
  logic pll_en_o, pll_lock_i = 1'b0, clk_en_o, cpu_clk_en_o, stby_no;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  lpm_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .wake_ni(wake_ni), .irq_ni(irq_ni), .bus_wake_ni(bus_wake_ni),
    .drain_req_o(drain_req_o), .drain_ack_i(drain_ack_i), .purge_req_o(purge_req_o),
    .purge_ack_i(purge_ack_i), .sref_req_o(sref_req_o), .sref_ack_i(sref_ack_i),
    .pll_en_o(pll_en_o), .pll_lock_i(pll_lock_i), .clk_en_o(clk_en_o),
    .cpu_clk_en_o(cpu_clk_en_o), .stby_no(stby_no)
  );

  // expected {cpu, clk, pll, stby_n, drain, purge, sref} per phase
  function automatic logic [6:0] exp_vec(phase_e p);
    case (p)
      P_RUN:    return 7'b1111000;
      P_SLEEP:  return 7'b0111000;
      P_DRAIN:  return 7'b1111100;
      P_PURGE:  return 7'b1111010;
      P_SREF:   return 7'b1111001;
      P_GATE:   return 7'b0011001;
      P_STBY:   return 7'b0000001;
      default:  return 7'b0011001;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata(logic [1:0] code);
    return (code == 2'b10 || code == 2'b11) ? {6'b0, code} : 8'h00;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ph(string req, phase_e p);
    chk(req, "outputs", {25'b0, cpu_clk_en_o, clk_en_o, pll_en_o, stby_no,
                         drain_req_o, purge_req_o, sref_req_o}, {25'b0, exp_vec(p)});
  endtask

  task automatic wr(logic [7:0] d);
    reg_we_i = 1'b1;
    reg_wdata_i = d;
    tick(1);
    reg_we_i = 1'b0;
  endtask

  task automatic run_sleep(bit use_bus, logic [5:0] upper);
    wr({upper, 2'b10});
    chk_ph("R3", P_SLEEP);
    chk("R2", "rdata", reg_rdata_o, exp_rdata(2'b10));
    wr(8'h03);
    chk_ph("R11", P_SLEEP);
    chk("R11", "rdata", reg_rdata_o, 8'h02);
    wake_ni = 1'b0;
    tick(SYNC + 2);
    chk_ph("R4", P_SLEEP);
    wake_ni = 1'b1;
    tick(SYNC + 1);
    if (use_bus) bus_wake_ni = 1'b0; else irq_ni = 1'b0;
    tick(SYNC);
    chk_ph("R4", P_SLEEP);
    tick(1);
    chk_ph("R4", P_RUN);
    chk("R4", "rdata", reg_rdata_o, 8'h00);
    irq_ni = 1'b1;
    bus_wake_ni = 1'b1;
    tick(SYNC + 1);
  endtask

  task automatic run_stby(int d0, int d1, int d2, bit early, logic [5:0] upper);
    wr({upper, 2'b11});
    chk_ph("R6", P_DRAIN);
    chk("R6", "rdata", reg_rdata_o, 8'h03);
    if (early) begin
      wake_ni = 1'b0;
      tick(1);
      wake_ni = 1'b1;
      d0 = d0 + SYNC + 1;
    end
    if (d0 >= 2) begin
      wr(8'h02);
      chk("R11", "rdata", reg_rdata_o, 8'h03);
      tick(d0 - 1);
      chk_ph("R7", P_DRAIN);
    end else if (d0 == 1) begin
      tick(1);
      chk_ph("R7", P_DRAIN);
    end
    drain_ack_i = 1'b1; tick(1); drain_ack_i = 1'b0;
    chk_ph("R6", P_PURGE);
    if (d1 > 0) begin tick(d1); chk_ph("R7", P_PURGE); end
    purge_ack_i = 1'b1; tick(1); purge_ack_i = 1'b0;
    chk_ph("R6", P_SREF);
    if (d2 > 0) begin tick(d2); chk_ph("R7", P_SREF); end
    sref_ack_i = 1'b1; tick(1); sref_ack_i = 1'b0;
    chk_ph("R6", P_GATE);
    tick(1);
    chk_ph("R6", P_STBY);
    if (early) begin
      tick(1);
      chk_ph("R9", P_RELOCK);
    end else begin
      irq_ni = 1'b0;
      bus_wake_ni = 1'b0;
      tick(SYNC + 2);
      chk_ph("R8", P_STBY);
      irq_ni = 1'b1;
      bus_wake_ni = 1'b1;
      tick(SYNC + 1);
      wake_ni = 1'b0;
      tick(SYNC);
      chk_ph("R8", P_STBY);
      tick(1);
      chk_ph("R8", P_RELOCK);
      wake_ni = 1'b1;
    end
    tick(2);
    chk_ph("R8", P_RELOCK);
    pll_lock_i = 1'b1; tick(1); pll_lock_i = 1'b0;
    chk_ph("R8", P_RUN);
    chk("R8", "rdata", reg_rdata_o, 8'h00);
    tick(SYNC + 1);
  endtask

  task automatic reset_pulse(string req);
    rst_ni = 1'b0;
    #1;
    chk_ph(req, P_RUN);
    chk(req, "rdata", reg_rdata_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick(SYNC + 1);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd7781));
    tick(3);
    chk_ph("R1", P_RUN);
    chk("R1", "rdata", reg_rdata_o, 8'h00);
    rst_ni = 1'b1;
    tick(1);
    chk_ph("R1", P_RUN);

    wr(8'hFD);
    chk_ph("R5", P_RUN);
    chk("R5", "rdata", reg_rdata_o, 8'h00);
    wr(8'h00);
    chk_ph("R5", P_RUN);

    run_sleep(1'b0, 6'h3F);
    run_sleep(1'b1, 6'h00);
    run_stby(0, 0, 0, 1'b0, 6'h00);
    run_stby(3, 2, 4, 1'b0, 6'h15);
    run_stby(1, 1, 1, 1'b1, 6'h2A);

    // reset out of deep and light states (R10)
    wr(8'h02);
    reset_pulse("R10");
    wr(8'h03);
    drain_ack_i = 1'b1; tick(1); drain_ack_i = 1'b0;
    purge_ack_i = 1'b1; tick(1); purge_ack_i = 1'b0;
    sref_ack_i = 1'b1; tick(1); sref_ack_i = 1'b0;
    tick(1);
    chk_ph("R6", P_STBY);
    reset_pulse("R10");
    wr(8'h03);
    tick(2);
    reset_pulse("R10");

    for (int i = 0; i < 40; i++) begin
      logic [1:0] code;
      logic [5:0] up;
      code = 2'($urandom % 4);
      up = 6'($urandom);
      case (code)
        2'b00, 2'b01: begin
          wr({up, code});
          chk_ph("R5", P_RUN);
          chk("R5", "rdata", reg_rdata_o, exp_rdata(code));
        end
        2'b10: run_sleep(1'($urandom % 2), up);
        default: run_stby(int'($urandom % 5), int'($urandom % 5), int'($urandom % 5),
                          ($urandom % 4) == 0, up);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule